// File: doc/BRIEF.md
# Three-Wire Serial Bus Monitor

This block watches a three-wire, half-duplex synchronous serial link without driving it. It takes the active-high select line, the serial clock, the controller-to-target data line and the target-to-controller data line. It passes each of them through a synchroniser in the system clock domain and detects their edges. It then turns each select window into a stream of result records. Every record carries a start and an end timestamp taken from a free-running sample counter.

A window is classed only once its first serial-clock rising edge has been seen. If that edge samples the input data line high, the window is a bit transfer. The monitor then emits one record per serial-clock period, holding the input bit taken at the rising edge, the output bit taken at the falling edge, and a flag that marks the leading start bit. If the window has no rising clock edge, or the first rising edge finds the input line low, the window is a status check. At the end of that window the monitor reports busy and ready intervals read from the output line. Two warning strobes report a clock that is already high when select rises and a transfer longer than the bit limit.

Top module: `mw_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `rec_valid`, `warn_sk_high` and `warn_overflow` are 0.
- R2: In a transfer window, a bit opens at a serial-clock rising edge and closes at the next one. Its record has `rec_kind` = 0 (bit), `rec_si` = the input line at the opening edge and `rec_so` = the output line at the last falling clock edge before it closes.
- R3: The first bit of a transfer window has `rec_first` = 1 and `rec_si` = 1. Every other record has `rec_first` = 0.
- R4: The last open bit closes when select falls while the clock is low. If select falls while the clock is high, that open bit produces no record.
- R5: A window with no serial-clock rising edge is a status check. It yields `rec_kind` = 1 (busy) and `rec_kind` = 2 (ready) records, and no bit records.
- R6: A window whose first serial-clock rising edge finds the input line low is a status check and produces no bit records.
- R7: In a status check where the output line is low when select rises and later goes high, a busy record spans window start to the first rising edge of the output line. A ready record spanning that edge to window end follows in the next cycle.
- R8: In a status check, an output line that is high when select rises gives one ready record over the whole window. A line that starts low and never rises gives one busy record over the whole window.
- R9: If the clock is high when select rises, `warn_sk_high` pulses for one cycle. The next clock rising edge still opens the first bit.
- R10: Once `MAX_BITS` bits of a window have been emitted, each further bit that closes produces no record and a one-cycle `warn_overflow` pulse instead.
- R11: The sample counter is 0 in reset and rises by one per clock. An input level first sampled at a clock edge where the counter holds c gets timestamp c+2. The record or warning caused by it is visible after the third edge, counting the sampling edge as the first.
- R12: A rising select edge clears all per-window state, so the bit count and the start-bit flag begin afresh in every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mw_cs | input | 1 | Bus select line, active high |
| mw_sk | input | 1 | Bus serial clock |
| mw_si | input | 1 | Data toward the target |
| mw_so | input | 1 | Data from the target |
| rec_valid | output | 1 | Record strobe, one cycle per record |
| rec_kind | output | 2 | 0 bit, 1 busy, 2 ready |
| rec_t_start | output | TS_W | Timestamp where the record's span begins |
| rec_t_end | output | TS_W | Timestamp where the record's span ends |
| rec_si | output | 1 | Input-line bit (bit records only) |
| rec_so | output | 1 | Output-line bit (bit records only) |
| rec_first | output | 1 | Start-bit flag |
| warn_sk_high | output | 1 | Clock found high as select rose |
| warn_overflow | output | 1 | Bit past the per-window limit |

## Verification
The hardest state to reach from the ports is the overflow boundary. Reaching it takes one window with more than 64 clock periods, where the 65th bit closes on a rising clock edge and the 66th closes when select falls. A long-window task drives exactly that sequence. A short window follows at once, to show that the count starts again. Ending a window while the clock is still high is the other awkward case. The stimulus raises the clock, drops select a few cycles later and only then lowers the clock, so the open bit must disappear without a record.

// File: rtl/mw_mon_pkg.sv
// Shared types and line indices for the serial bus monitor.
package mw_mon_pkg;

    typedef enum logic [1:0] {
        REC_BIT   = 2'd0,
        REC_BUSY  = 2'd1,
        REC_READY = 2'd2
    } rec_kind_e;

    localparam int unsigned LN_CS   = 0;
    localparam int unsigned LN_SK   = 1;
    localparam int unsigned LN_SI   = 2;
    localparam int unsigned LN_SO   = 3;
    localparam int unsigned N_LINES = 4;

endpackage

// File: rtl/mw_line_sync.sv
// Synchronises N asynchronous lines and reports level, rise and fall.
// Assumes STAGES >= 2. The level is the last synchroniser stage. Edges
// compare it with one extra history flop, so edges are combinational from
// registers. Every flop resets to 0.
module mw_line_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              hist;

        // Shift the raw line through the synchroniser and keep one history bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                hist  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                hist  <= chain[STAGES-1];
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~hist;
        assign fall[g] = ~chain[STAGES-1] & hist;
    end

endmodule

// File: rtl/mw_bit_track.sv
// Tracks one select window, classes it from the first clock rising edge,
// and assembles bit records for transfer windows.
// Assumes synchronised inputs. At most one select edge occurs per cycle.
module mw_bit_track #(
    parameter int unsigned TS_W     = 32,
    parameter int unsigned MAX_BITS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            cs_rise,
    input  logic            cs_fall,
    input  logic            sk_lvl,
    input  logic            sk_rise,
    input  logic            sk_fall,
    input  logic            si_lvl,
    input  logic            so_lvl,
    output logic            xfer_win,
    output logic            bit_valid,
    output logic [TS_W-1:0] bit_t0,
    output logic [TS_W-1:0] bit_t1,
    output logic            bit_si,
    output logic            bit_so,
    output logic            bit_first,
    output logic            warn_sk_high,
    output logic            warn_ovf
);

    localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);

    logic             in_win, seen_rise, open_q, si_q, so_q, first_q;
    logic [TS_W-1:0]  t0_q;
    logic [CNT_W-1:0] nbits;
    logic             close_mid, close_last, close_any, room;

    // Decide whether an open bit ends in this cycle and whether it may be emitted.
    always_comb begin
        close_mid  = in_win & ~cs_rise & ~cs_fall & sk_rise & seen_rise & xfer_win;
        close_last = in_win & cs_fall & xfer_win & open_q & ~sk_lvl;
        close_any  = close_mid | close_last;
        room       = nbits < CNT_W'(MAX_BITS);
    end

    // Window state, classification and bit assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_win <= 1'b0;  seen_rise <= 1'b0; xfer_win <= 1'b0;
            open_q <= 1'b0;  si_q <= 1'b0;      so_q <= 1'b0;
            first_q <= 1'b0; t0_q <= '0;        nbits <= '0;
            bit_valid <= 1'b0; bit_t0 <= '0; bit_t1 <= '0;
            bit_si <= 1'b0; bit_so <= 1'b0; bit_first <= 1'b0;
            warn_sk_high <= 1'b0; warn_ovf <= 1'b0;
        end else begin
            bit_valid    <= 1'b0;
            warn_sk_high <= 1'b0;
            warn_ovf     <= 1'b0;
            if (close_any) begin
                if (room) begin
                    bit_valid <= 1'b1;
                    bit_t0    <= t0_q;
                    bit_t1    <= now;
                    bit_si    <= si_q;
                    bit_so    <= so_q;
                    bit_first <= first_q;
                    nbits     <= nbits + 1'b1;
                end else begin
                    warn_ovf <= 1'b1;
                end
            end
            if (cs_rise) begin
                in_win       <= 1'b1;
                seen_rise    <= 1'b0;
                xfer_win     <= 1'b0;
                open_q       <= 1'b0;
                so_q         <= 1'b0;
                first_q      <= 1'b0;
                nbits        <= '0;
                warn_sk_high <= sk_lvl;
            end else if (in_win && cs_fall) begin
                in_win <= 1'b0;
                open_q <= 1'b0;
            end else if (in_win) begin
                if (sk_rise) begin
                    if (!seen_rise) begin
                        seen_rise <= 1'b1;
                        xfer_win  <= si_lvl;
                        if (si_lvl) begin
                            open_q  <= 1'b1;
                            t0_q    <= now;
                            si_q    <= 1'b1;
                            first_q <= 1'b1;
                        end
                    end else if (xfer_win) begin
                        t0_q    <= now;
                        si_q    <= si_lvl;
                        first_q <= 1'b0;
                    end
                end
                if (sk_fall) begin
                    so_q <= so_lvl;
                end
            end
        end
    end

endmodule

// File: rtl/mw_status_track.sv
// Follows the output line during a select window. When a window that is not
// a transfer ends, it emits busy/ready interval records. Assumes xfer_win
// is valid in the cycle the select fall is detected.
module mw_status_track
    import mw_mon_pkg::*;
#(
    parameter int unsigned TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            cs_rise,
    input  logic            cs_fall,
    input  logic            so_lvl,
    input  logic            so_rise,
    input  logic            xfer_win,
    output logic            st_valid,
    output rec_kind_e       st_kind,
    output logic [TS_W-1:0] st_t0,
    output logic [TS_W-1:0] st_t1
);

    logic            win, so_init, rose, pend;
    logic [TS_W-1:0] w_t0, rise_t, end_t;

    // Record window start, first output-line rise and emit intervals at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= 1'b0; so_init <= 1'b0; rose <= 1'b0; pend <= 1'b0;
            w_t0 <= '0; rise_t <= '0; end_t <= '0;
            st_valid <= 1'b0; st_kind <= REC_BUSY; st_t0 <= '0; st_t1 <= '0;
        end else begin
            st_valid <= 1'b0;
            pend     <= 1'b0;
            if (pend) begin
                st_valid <= 1'b1;
                st_kind  <= REC_READY;
                st_t0    <= rise_t;
                st_t1    <= end_t;
            end
            if (cs_rise) begin
                win     <= 1'b1;
                w_t0    <= now;
                so_init <= so_lvl;
                rose    <= 1'b0;
            end else if (win && cs_fall) begin
                win <= 1'b0;
                if (!xfer_win) begin
                    st_valid <= 1'b1;
                    st_t0    <= w_t0;
                    if (so_init) begin
                        st_kind <= REC_READY;
                        st_t1   <= now;
                    end else if (rose) begin
                        st_kind <= REC_BUSY;
                        st_t1   <= rise_t;
                        end_t   <= now;
                        pend    <= 1'b1;
                    end else begin
                        st_kind <= REC_BUSY;
                        st_t1   <= now;
                    end
                end
            end else if (win && so_rise && !so_init && !rose) begin
                rose   <= 1'b1;
                rise_t <= now;
            end
        end
    end

endmodule

// File: rtl/mw_monitor.sv
// Passive monitor for a three-wire half-duplex serial bus. Synchronises
// the four lines, timestamps events with a free-running counter and
// merges bit and status records onto one strobed output. Bit and status
// records never fall in the same cycle, because one window has one class.
module mw_monitor
    import mw_mon_pkg::*;
#(
    parameter int unsigned TS_W        = 32,
    parameter int unsigned MAX_BITS    = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mw_cs,
    input  logic            mw_sk,
    input  logic            mw_si,
    input  logic            mw_so,
    output logic            rec_valid,
    output logic [1:0]      rec_kind,
    output logic [TS_W-1:0] rec_t_start,
    output logic [TS_W-1:0] rec_t_end,
    output logic            rec_si,
    output logic            rec_so,
    output logic            rec_first,
    output logic            warn_sk_high,
    output logic            warn_overflow
);

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    logic [TS_W-1:0]    now;
    logic               xfer_win;
    logic               bit_valid, bit_si, bit_so, bit_first;
    logic [TS_W-1:0]    bit_t0, bit_t1, st_t0, st_t1;
    logic               st_valid;
    rec_kind_e          st_kind;

    assign raw[LN_CS] = mw_cs;
    assign raw[LN_SK] = mw_sk;
    assign raw[LN_SI] = mw_si;
    assign raw[LN_SO] = mw_so;

    // Free-running sample counter used for every timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    mw_line_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .lvl(lvl), .rise(rise), .fall(fall)
    );

    mw_bit_track #(.TS_W(TS_W), .MAX_BITS(MAX_BITS)) u_bits (
        .clk(clk), .rst_n(rst_n), .now(now),
        .cs_rise(rise[LN_CS]), .cs_fall(fall[LN_CS]),
        .sk_lvl(lvl[LN_SK]), .sk_rise(rise[LN_SK]), .sk_fall(fall[LN_SK]),
        .si_lvl(lvl[LN_SI]), .so_lvl(lvl[LN_SO]),
        .xfer_win(xfer_win),
        .bit_valid(bit_valid), .bit_t0(bit_t0), .bit_t1(bit_t1),
        .bit_si(bit_si), .bit_so(bit_so), .bit_first(bit_first),
        .warn_sk_high(warn_sk_high), .warn_ovf(warn_overflow)
    );

    mw_status_track #(.TS_W(TS_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .now(now),
        .cs_rise(rise[LN_CS]), .cs_fall(fall[LN_CS]),
        .so_lvl(lvl[LN_SO]), .so_rise(rise[LN_SO]), .xfer_win(xfer_win),
        .st_valid(st_valid), .st_kind(st_kind), .st_t0(st_t0), .st_t1(st_t1)
    );

    // Merge the two record sources onto the output record.
    always_comb begin
        rec_valid   = st_valid | bit_valid;
        rec_kind    = st_valid ? st_kind : REC_BIT;
        rec_t_start = st_valid ? st_t0 : bit_t0;
        rec_t_end   = st_valid ? st_t1 : bit_t1;
        rec_si      = st_valid ? 1'b0 : bit_si;
        rec_so      = st_valid ? 1'b0 : bit_so;
        rec_first   = st_valid ? 1'b0 : bit_first;
    end

endmodule

// File: rtl/mw_monitor_chk.sv
// Temporal checks on the monitor's outputs, attached by bind.
module mw_monitor_chk #(
    parameter int unsigned TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rec_valid,
    input logic [1:0]      rec_kind,
    input logic [TS_W-1:0] rec_t_start,
    input logic [TS_W-1:0] rec_t_end,
    input logic            rec_si,
    input logic            rec_first,
    input logic            warn_sk_high,
    input logic            warn_overflow
);

    // R1: reset leaves no record strobe behind it.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rec_valid);

    // R2: a record's span never runs backwards.
    assert_span_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_t_end >= rec_t_start);

    // R3: only bit records may carry the start flag, and a start bit is high.
    assert_first_is_high_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_first) |-> (rec_kind == 2'd0 && rec_si));

    // R7: a busy record is followed by nothing or by the matching ready record.
    assert_ready_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_kind == 2'd1) |=>
            (!rec_valid || (rec_kind == 2'd2 && rec_t_start == $past(rec_t_end))));

    // R9: the clock-high warning is a single-cycle pulse.
    assert_sk_warn_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_sk_high |=> !warn_sk_high);

    // R10: an overflowing bit produces no record.
    assert_overflow_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        warn_overflow |-> !rec_valid);

endmodule

bind mw_monitor mw_monitor_chk #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .rec_t_start(rec_t_start), .rec_t_end(rec_t_end), .rec_si(rec_si),
    .rec_first(rec_first), .warn_sk_high(warn_sk_high),
    .warn_overflow(warn_overflow)
);

// File: tb/mw_monitor_bench.sv
// Behavioural reference model of the bus monitor, compared every clock.
module mw_monitor_bench;

    localparam int TS_W     = 32;
    localparam int MAX_BITS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
    logic            rec_valid, rec_si, rec_so, rec_first, warn_sk_high, warn_overflow;
    logic [1:0]      rec_kind;
    logic [TS_W-1:0] rec_t_start, rec_t_end;

    always #4 clk = ~clk;

    mw_monitor #(.TS_W(TS_W), .MAX_BITS(MAX_BITS)) u_mw_monitor (
        .clk(clk), .rst_n(rst_n), .mw_cs(cs), .mw_sk(sk), .mw_si(si), .mw_so(so),
        .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_t_start(rec_t_start),
        .rec_t_end(rec_t_end), .rec_si(rec_si), .rec_so(rec_so),
        .rec_first(rec_first), .warn_sk_high(warn_sk_high),
        .warn_overflow(warn_overflow)
    );

    typedef struct {
        longint due;
        int     kind;
        longint t0;
        longint t1;
        bit     si;
        bit     so;
        bit     first;
        int     req;
    } exp_t;

    exp_t   q_rec[$];
    longint q_wsk[$];
    longint q_ovf[$];

    int checks = 0;
    int errors = 0;
    int n_bit = 0, n_busy = 0, n_ready = 0, n_wsk = 0, n_ovf = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    longint cnt = 0;
    bit p_cs, p_sk, p_so;
    bit m_win, m_seen, m_xfer, m_open, m_si, m_so, m_first, m_init, m_rose;
    longint m_t0, m_wt0, m_riset;
    int m_nbits;

    function automatic void close_bit(input longint c, input int req);
        exp_t e;
        if (m_nbits < MAX_BITS) begin
            e.due = c + 3; e.kind = 0; e.t0 = m_t0; e.t1 = c + 2;
            e.si = m_si; e.so = m_so; e.first = m_first;
            e.req = m_first ? 3 : req;
            q_rec.push_back(e);
            m_nbits++;
        end else begin
            q_ovf.push_back(c + 3);
        end
    endfunction

    function automatic void push_stat(input longint due, input int kind,
                                      input longint t0, input longint t1, input int req);
        exp_t e;
        e.due = due; e.kind = kind; e.t0 = t0; e.t1 = t1;
        e.si = 0; e.so = 0; e.first = 0; e.req = req;
        q_rec.push_back(e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; p_cs = 0; p_sk = 0; p_so = 0;
            m_win = 0; m_seen = 0; m_xfer = 0; m_open = 0; m_nbits = 0;
        end else begin
            longint c;
            c = cnt;
            if (cs && !p_cs) begin
                m_win = 1; m_seen = 0; m_xfer = 0; m_open = 0; m_so = 0;
                m_first = 0; m_nbits = 0; m_wt0 = c + 2; m_init = so; m_rose = 0;
                if (sk) q_wsk.push_back(c + 3);
            end else if (!cs && p_cs && m_win) begin
                m_win = 0;
                if (m_xfer && m_open && !sk) close_bit(c, 4);
                if (!m_xfer) begin
                    int rq;
                    rq = m_seen ? 6 : 5;
                    if (m_init) push_stat(c + 3, 2, m_wt0, c + 2, rq);
                    else if (m_rose) begin
                        push_stat(c + 3, 1, m_wt0, m_riset, 7);
                        push_stat(c + 4, 2, m_riset, c + 2, 7);
                    end else push_stat(c + 3, 1, m_wt0, c + 2, rq);
                end
                m_open = 0;
            end else if (m_win) begin
                if (sk && !p_sk) begin
                    if (!m_seen) begin
                        m_seen = 1; m_xfer = si;
                        if (si) begin m_open = 1; m_t0 = c + 2; m_si = 1; m_first = 1; end
                    end else if (m_xfer) begin
                        close_bit(c, 2);
                        m_t0 = c + 2; m_si = si; m_first = 0;
                    end
                end
                if (!sk && p_sk) m_so = so;
                if (so && !p_so && !m_init && !m_rose) begin m_rose = 1; m_riset = c + 2; end
            end
            p_cs = cs; p_sk = sk; p_so = so;
            cnt = c + 1;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            while (q_rec.size() > 0 && q_rec[0].due < cnt) begin
                chk(0, $sformatf("R%0d missed record", q_rec[0].req), 0, 1);
                void'(q_rec.pop_front());
            end
            if (q_rec.size() > 0 && q_rec[0].due == cnt) begin
                exp_t e;
                e = q_rec.pop_front();
                chk(rec_valid == 1'b1, $sformatf("R%0d record strobe", e.req), rec_valid, 1);
                if (rec_valid) begin
                    chk(rec_kind == e.kind[1:0], $sformatf("R%0d kind", e.req), rec_kind, e.kind);
                    chk(rec_si == e.si, $sformatf("R%0d si", e.req), rec_si, e.si);
                    chk(rec_so == e.so, $sformatf("R%0d so", e.req), rec_so, e.so);
                    chk(rec_first == e.first, "R3 first flag", rec_first, e.first);
                    chk(rec_t_start == e.t0[TS_W-1:0], "R11 start stamp", rec_t_start, e.t0);
                    chk(rec_t_end == e.t1[TS_W-1:0], "R11 end stamp", rec_t_end, e.t1);
                end
            end else if (rec_valid) begin
                chk(0, "R6 unexpected record", 1, 0);
            end
            if (q_wsk.size() > 0 && q_wsk[0] == cnt) begin
                void'(q_wsk.pop_front());
                chk(warn_sk_high == 1'b1, "R9 clock-high warning", warn_sk_high, 1);
            end else if (warn_sk_high) chk(0, "R9 stray clock-high warning", 1, 0);
            if (q_ovf.size() > 0 && q_ovf[0] == cnt) begin
                void'(q_ovf.pop_front());
                chk(warn_overflow == 1'b1, "R10 overflow warning", warn_overflow, 1);
            end else if (warn_overflow) chk(0, "R10 stray overflow warning", 1, 0);
            if (rec_valid && rec_kind == 2'd0) n_bit++;
            if (rec_valid && rec_kind == 2'd1) n_busy++;
            if (rec_valid && rec_kind == 2'd2) n_ready++;
            if (warn_sk_high) n_wsk++;
            if (warn_overflow) n_ovf++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit si_v, input bit so_v);
        si = si_v; step(2);
        sk = 1'b1; step(2);
        so = so_v; step(2);
        sk = 1'b0; step(2);
    endtask

    task automatic cs_on();
        cs = 1'b1; step(4);
    endtask

    task automatic cs_off();
        cs = 1'b0; step(8);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int b0, bs0, rd0;
        step(3);
        // R1: quiet during reset
        chk(rec_valid == 0 && warn_sk_high == 0 && warn_overflow == 0, "R1 in reset", rec_valid, 0);
        rst_n = 1'b1;
        step(1);
        chk(rec_valid == 0 && warn_sk_high == 0 && warn_overflow == 0, "R1 after release", rec_valid, 0);
        step(4);

        // R2, R3, R4, R11: plain transfer of five bits ending with clock low
        b0 = n_bit;
        cs_on();
        send_bit(1, 0); send_bit(0, 1); send_bit(1, 1); send_bit(1, 0); send_bit(0, 1);
        cs_off();
        chk(n_bit - b0 == 5, "R2 bit count", n_bit - b0, 5);

        // R4: select falls while clock is high, open bit dropped
        b0 = n_bit;
        so = 1'b0; cs_on();
        send_bit(1, 1); send_bit(0, 0); send_bit(1, 1);
        si = 1'b1; step(2); sk = 1'b1; step(3);
        cs = 1'b0; step(3); sk = 1'b0; step(8);
        chk(n_bit - b0 == 3, "R4 dropped open bit", n_bit - b0, 3);

        // R5, R7: no clock, output line rises mid-window
        so = 1'b0; step(2);
        bs0 = n_busy; rd0 = n_ready;
        cs_on(); step(10); so = 1'b1; step(10);
        cs_off();
        chk(n_busy - bs0 == 1 && n_ready - rd0 == 1, "R7 busy then ready", n_ready - rd0, 1);

        // R6, R8: first rising edge with SI low, output line high at start
        so = 1'b1; step(2);
        b0 = n_bit; bs0 = n_busy; rd0 = n_ready;
        cs_on(); send_bit(0, 0); send_bit(1, 1);
        cs_off();
        chk(n_bit - b0 == 0, "R6 no bit records", n_bit - b0, 0);
        chk(n_ready - rd0 == 1 && n_busy - bs0 == 0, "R8 single ready", n_ready - rd0, 1);

        // R8: output line low and never rising
        so = 1'b0; step(2);
        bs0 = n_busy; rd0 = n_ready;
        cs_on(); step(20);
        cs_off();
        chk(n_busy - bs0 == 1 && n_ready - rd0 == 0, "R8 single busy", n_busy - bs0, 1);

        // R9: clock high when select rises
        b0 = n_bit;
        sk = 1'b1; step(2);
        cs = 1'b1; step(3); sk = 1'b0; step(3);
        send_bit(1, 1); send_bit(0, 0);
        cs_off();
        chk(n_wsk == 1, "R9 warning count", n_wsk, 1);
        chk(n_bit - b0 == 2, "R9 first edge counted", n_bit - b0, 2);

        // R10: 66 bits in one window
        b0 = n_bit;
        so = 1'b0; cs_on();
        for (int i = 0; i < 66; i++) send_bit((i == 0) ? 1'b1 : 1'(i % 2), 1'(i % 3 == 0));
        cs_off();
        chk(n_bit - b0 == MAX_BITS, "R10 records capped", n_bit - b0, MAX_BITS);
        chk(n_ovf == 2, "R10 overflow count", n_ovf, 2);

        // R12: next window starts afresh
        b0 = n_bit;
        cs_on(); send_bit(1, 1); send_bit(1, 0);
        cs_off();
        chk(n_bit - b0 == 2, "R12 fresh count", n_bit - b0, 2);
        chk(q_rec.size() == 0, "R12 model drained", q_rec.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule